// File: doc/BRIEF.md
# Banked CPU Bus Address Decoder

This block sits on the bus of an 8-bit processor core. It sends every access to one of three places. The first is an internal work RAM at the bottom of the address map. The second is a short table of programmable peripheral windows. The third is an external paged memory. The paged memory sees the 16-bit CPU address through a set of bank base registers. The top address bits choose a bank register. That register's base replaces them in the physical address, and the low bits pass through as the offset inside the bank.

Reads and writes follow different decode paths. A read in the upper half of the map always goes to paged memory. A write there still searches the peripheral windows first. The window search runs in table order. It stops at the first entry that is enabled and whose inclusive range covers the address. It also stops at the first entry whose lower bound is all ones, which ends the table. A read can ask for a 16-bit little-endian word. The byte at the address and the byte at the address plus one are then decoded on two independent lanes, and both are returned on the single read data port one clock later. The bank bases and the window table are loaded through separate configuration ports.

Top module: `cpu_bus_router`

## Requirements
- R1: Any access with address below 0x0800 reads or writes the internal work RAM and raises no peripheral or paged strobe.
- R2: A read with address 0x8000 or above goes to paged memory and never raises a peripheral select, even when an enabled window covers it.
- R3: A write with address 0x0800 or above is checked against the window table. This includes addresses at 0x8000 and above. A covering window receives the write (`dev_we`, `dev_sel[0]`).
- R4: Windows are searched from index 0 upward. The first enabled entry with lo <= address <= hi wins, both bounds inclusive. Its index appears on the lane's 2-bit field of `dev_idx` (lane 0 in bits 1:0, lane 1 in bits 3:2).
- R5: An entry whose lo bound is 0xFFFF ends the search, so entries after it are never matched. A disabled entry is skipped.
- R6: An access above the RAM region that matches no window goes to paged memory.
- R7: The paged physical address of a lane is {base[addr[15:12]], addr[11:0]}. Lane 0 is on bits 17:0 of `pg_addr` and lane 1 on bits 35:18. Reset sets base[i] = i. A configuration write replaces one base from the next cycle on.
- R8: A word read returns the byte at A in bits 7:0 and the byte at (A+1) mod 65536 in bits 15:8, each byte decoded by the read rules on its own. A byte read returns zero in bits 15:8.
- R9: Read data and `bus_rvalid` appear in the cycle after the read strobe, and `bus_rvalid` lasts one cycle per read cycle. Strobes to the targets are asserted in the same cycle as the access. A write takes effect at the clock edge that ends its cycle.
- R10: A cycle with both read and write strobes acts as a write only and produces no `bus_rvalid`.
- R11: After reset `bus_rvalid` and `bus_rdata` are zero. Every window entry is disabled and holds the end-of-table marker, so all accesses above the RAM go to paged memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | Read returns a 16-bit word instead of a byte |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| cfg_bank_we | input | 1 | Load one bank base |
| cfg_bank_sel | input | 4 | Bank register to load |
| cfg_bank_base | input | 6 | New bank base |
| cfg_win_we | input | 1 | Load one window entry |
| cfg_win_sel | input | 2 | Window entry to load |
| cfg_win_lo | input | 16 | Window lower bound (inclusive) |
| cfg_win_hi | input | 16 | Window upper bound (inclusive) |
| cfg_win_en | input | 1 | Window enable |
| dev_sel | output | 2 | Per-lane peripheral select strobe |
| dev_idx | output | 4 | Per-lane matching window index |
| dev_addr | output | 32 | Per-lane CPU address for peripherals |
| dev_we | output | 1 | Peripheral write strobe (lane 0) |
| dev_rdata | input | 16 | Per-lane peripheral read byte |
| pg_rd | output | 2 | Per-lane paged read strobe |
| pg_we | output | 1 | Paged write strobe (lane 0) |
| pg_addr | output | 36 | Per-lane paged physical address |
| pg_rdata | input | 16 | Per-lane paged read byte |
| out_wdata | output | 8 | Write data to peripherals and paged memory |

## Verification
A wrong window register or a broken priority chain shows at the ports in the same cycle as the access. The select, index or paged strobe goes to the wrong place. A wrong bank base shows the same way, as a wrong physical address on `pg_addr`. Corrupt work RAM contents or a bad lane-1 decode appear one cycle later as a wrong byte in `bus_rdata`. The bench compares every cycle's strobes and every returned word against its own decode of the address map, so an error surfaces on the first access that touches the faulty entry.

// File: rtl/bus_router_pkg.sv
package bus_router_pkg;
  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_DEV  = 2'd1,
    TGT_PAGE = 2'd2
  } tgt_e;
endpackage

// File: rtl/bus_win_table.sv
module bus_win_table #(
  parameter int ADDR_W  = 16,
  parameter int NUM_WIN = 4,
  parameter int LANES   = 2,
  localparam int IW     = $clog2(NUM_WIN)
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    cfg_we,
  input  logic [IW-1:0]           cfg_sel,
  input  logic [ADDR_W-1:0]       cfg_lo,
  input  logic [ADDR_W-1:0]       cfg_hi,
  input  logic                    cfg_en,
  input  logic [LANES*ADDR_W-1:0] lk_addr,
  output logic [LANES-1:0]        lk_hit,
  output logic [LANES*IW-1:0]     lk_idx
);
  localparam logic [ADDR_W-1:0] END_MARK = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] lo_q [NUM_WIN];
  logic [ADDR_W-1:0] hi_q [NUM_WIN];
  logic [NUM_WIN-1:0] en_q;
  logic [ADDR_W-1:0] lo_d [NUM_WIN];
  logic [ADDR_W-1:0] hi_d [NUM_WIN];
  logic [NUM_WIN-1:0] en_d;

  always_comb begin
    for (int i = 0; i < NUM_WIN; i++) begin
      lo_d[i] = lo_q[i];
      hi_d[i] = hi_q[i];
      en_d[i] = en_q[i];
      if (cfg_we && (cfg_sel == IW'(i))) begin
        lo_d[i] = cfg_lo;
        hi_d[i] = cfg_hi;
        en_d[i] = cfg_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        lo_q[i] <= END_MARK;
        hi_q[i] <= END_MARK;
      end
      en_q <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        lo_q[i] <= lo_d[i];
        hi_q[i] <= hi_d[i];
      end
      en_q <= en_d;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lookup
    logic [ADDR_W-1:0] a;
    logic              hit;
    logic [IW-1:0]     idx;
    logic              stop;
    assign a = lk_addr[l*ADDR_W +: ADDR_W];

    always_comb begin
      hit  = 1'b0;
      idx  = '0;
      stop = 1'b0;
      for (int i = 0; i < NUM_WIN; i++) begin
        if (!stop) begin
          if (lo_q[i] == END_MARK) begin
            stop = 1'b1;
          end else if (en_q[i] && (a >= lo_q[i]) && (a <= hi_q[i])) begin
            hit  = 1'b1;
            idx  = IW'(i);
            stop = 1'b1;
          end
        end
      end
    end

    assign lk_hit[l]            = hit;
    assign lk_idx[l*IW +: IW]   = idx;
  end
endmodule

// File: rtl/bus_bank_map.sv
module bus_bank_map #(
  parameter int ADDR_W     = 16,
  parameter int BANK_SHIFT = 12,
  parameter int BASE_W     = 6,
  parameter int LANES      = 2,
  localparam int BANK_IW   = ADDR_W - BANK_SHIFT,
  localparam int NUM_BANKS = 1 << BANK_IW,
  localparam int PHYS_W    = BASE_W + BANK_SHIFT
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    cfg_we,
  input  logic [BANK_IW-1:0]      cfg_sel,
  input  logic [BASE_W-1:0]       cfg_base,
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  output logic [LANES*PHYS_W-1:0] lane_phys
);
  logic [BASE_W-1:0] base_q [NUM_BANKS];
  logic [BASE_W-1:0] base_d [NUM_BANKS];

  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) begin
      base_d[i] = base_q[i];
      if (cfg_we && (cfg_sel == BANK_IW'(i))) base_d[i] = cfg_base;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BANKS; i++) base_q[i] <= BASE_W'(i);
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_BANKS; i++) base_q[i] <= base_d[i];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_xlate
    logic [ADDR_W-1:0]  a;
    logic [BANK_IW-1:0] bank;
    assign a    = lane_addr[l*ADDR_W +: ADDR_W];
    assign bank = a[ADDR_W-1:BANK_SHIFT];
    assign lane_phys[l*PHYS_W +: PHYS_W] = {base_q[bank], a[BANK_SHIFT-1:0]};
  end
endmodule

// File: rtl/bus_work_ram.sv
module bus_work_ram #(
  parameter int AW    = 11,
  parameter int DW    = 8,
  parameter int LANES = 2,
  localparam int DEPTH = 1 << AW
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [DW-1:0]       wdata,
  input  logic [LANES*AW-1:0] raddr,
  output logic [LANES*DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_port
    assign rdata[l*DW +: DW] = mem[raddr[l*AW +: AW]];
  end
endmodule

// File: rtl/cpu_bus_router.sv
module cpu_bus_router
  import bus_router_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int BANK_SHIFT   = 12,
  parameter int BASE_W       = 6,
  parameter int NUM_WIN      = 4,
  parameter int RAM_LIMIT    = 32'h0800,
  parameter int PAGE_ONLY_RD = 32'h8000,
  localparam int LANES       = 2,
  localparam int WIN_IW      = $clog2(NUM_WIN),
  localparam int BANK_IW     = ADDR_W - BANK_SHIFT,
  localparam int PHYS_W      = BASE_W + BANK_SHIFT,
  localparam int RAM_AW      = $clog2(RAM_LIMIT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_rd,
  input  logic                    bus_wr,
  input  logic                    bus_word,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [LANES*DATA_W-1:0] bus_rdata,
  output logic                    bus_rvalid,
  input  logic                    cfg_bank_we,
  input  logic [BANK_IW-1:0]      cfg_bank_sel,
  input  logic [BASE_W-1:0]       cfg_bank_base,
  input  logic                    cfg_win_we,
  input  logic [WIN_IW-1:0]       cfg_win_sel,
  input  logic [ADDR_W-1:0]       cfg_win_lo,
  input  logic [ADDR_W-1:0]       cfg_win_hi,
  input  logic                    cfg_win_en,
  output logic [LANES-1:0]        dev_sel,
  output logic [LANES*WIN_IW-1:0] dev_idx,
  output logic [LANES*ADDR_W-1:0] dev_addr,
  output logic                    dev_we,
  input  logic [LANES*DATA_W-1:0] dev_rdata,
  output logic [LANES-1:0]        pg_rd,
  output logic                    pg_we,
  output logic [LANES*PHYS_W-1:0] pg_addr,
  input  logic [LANES*DATA_W-1:0] pg_rdata,
  output logic [DATA_W-1:0]       out_wdata
);
  localparam logic [ADDR_W-1:0] RAM_LIM_A  = ADDR_W'(RAM_LIMIT);
  localparam logic [ADDR_W-1:0] PAGE_LIM_A = ADDR_W'(PAGE_ONLY_RD);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Access qualification
  logic                    rd_go;
  logic [LANES-1:0]        lane_act;
  logic [LANES*ADDR_W-1:0] lane_addr;
  assign rd_go     = bus_rd & ~bus_wr;
  assign lane_act  = {rd_go & bus_word, rd_go | bus_wr};
  assign lane_addr = {ADDR_W'(bus_addr + 1'b1), bus_addr};

  // Window table and bank translation
  logic [LANES-1:0]        win_hit;
  logic [LANES*WIN_IW-1:0] win_idx;
  logic [LANES*PHYS_W-1:0] phys;

  bus_win_table #(
    .ADDR_W (ADDR_W),
    .NUM_WIN(NUM_WIN),
    .LANES  (LANES)
  ) u_win (
    .clk    (clk),
    .rst_ni (rst_ni),
    .cfg_we (cfg_win_we),
    .cfg_sel(cfg_win_sel),
    .cfg_lo (cfg_win_lo),
    .cfg_hi (cfg_win_hi),
    .cfg_en (cfg_win_en),
    .lk_addr(lane_addr),
    .lk_hit (win_hit),
    .lk_idx (win_idx)
  );

  bus_bank_map #(
    .ADDR_W    (ADDR_W),
    .BANK_SHIFT(BANK_SHIFT),
    .BASE_W    (BASE_W),
    .LANES     (LANES)
  ) u_bank (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .cfg_we   (cfg_bank_we),
    .cfg_sel  (cfg_bank_sel),
    .cfg_base (cfg_bank_base),
    .lane_addr(lane_addr),
    .lane_phys(phys)
  );

  // Per-lane target decode and byte selection
  logic [LANES-1:0]        is_ram;
  logic [LANES-1:0]        is_dev;
  logic [LANES-1:0]        is_pg;
  logic [LANES*RAM_AW-1:0] ram_raddr;
  logic [LANES*DATA_W-1:0] ram_rdata;
  logic [LANES*DATA_W-1:0] lane_byte;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] a;
    tgt_e              tgt;
    logic [DATA_W-1:0] byte_sel;
    assign a = lane_addr[l*ADDR_W +: ADDR_W];

    always_comb begin
      if (a < RAM_LIM_A)                   tgt = TGT_RAM;
      else if (rd_go && (a >= PAGE_LIM_A)) tgt = TGT_PAGE;
      else if (win_hit[l])                 tgt = TGT_DEV;
      else                                 tgt = TGT_PAGE;
    end

    always_comb begin
      case (tgt)
        TGT_RAM: byte_sel = ram_rdata[l*DATA_W +: DATA_W];
        TGT_DEV: byte_sel = dev_rdata[l*DATA_W +: DATA_W];
        default: byte_sel = pg_rdata[l*DATA_W +: DATA_W];
      endcase
    end

    assign is_ram[l] = (tgt == TGT_RAM);
    assign is_dev[l] = (tgt == TGT_DEV);
    assign is_pg[l]  = (tgt == TGT_PAGE);
    assign ram_raddr[l*RAM_AW +: RAM_AW] = a[RAM_AW-1:0];
    assign lane_byte[l*DATA_W +: DATA_W] = byte_sel;
  end

  // Work RAM (write on lane 0 only)
  logic ram_we;
  assign ram_we = bus_wr & is_ram[0];

  bus_work_ram #(
    .AW   (RAM_AW),
    .DW   (DATA_W),
    .LANES(LANES)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(bus_addr[RAM_AW-1:0]),
    .wdata(bus_wdata),
    .raddr(ram_raddr),
    .rdata(ram_rdata)
  );

  // Target strobes
  assign dev_sel   = is_dev & lane_act;
  assign dev_idx   = win_idx;
  assign dev_addr  = lane_addr;
  assign dev_we    = bus_wr & is_dev[0];
  assign pg_rd     = is_pg & lane_act & {LANES{rd_go}};
  assign pg_we     = bus_wr & is_pg[0];
  assign pg_addr   = phys;
  assign out_wdata = bus_wdata;

  // Registered read return
  logic [LANES*DATA_W-1:0] rdata_q, rdata_d;
  logic                    rvalid_q, rvalid_d;

  always_comb begin
    rvalid_d = rd_go;
    rdata_d  = {lane_byte[2*DATA_W-1:DATA_W] & {DATA_W{bus_word}},
                lane_byte[DATA_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      if (rd_go) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R9
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && !bus_wr) |=> bus_rvalid);

  // R10
  write_wins_over_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && bus_wr) |=> !bus_rvalid);

  // R1
  ram_region_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((bus_rd || bus_wr) && (bus_addr < RAM_LIM_A)) |->
      (!dev_sel[0] && !pg_rd[0] && !pg_we && !dev_we));

  // R2
  high_read_no_window_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && !bus_wr && (bus_addr >= PAGE_LIM_A)) |-> (pg_rd[0] && !dev_sel[0]));

  // R3
  single_write_target_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({pg_we, dev_we}) && (bus_wr || (!pg_we && !dev_we)));

  // R8
  upper_lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_rd && !bus_wr && bus_word) |-> (!dev_sel[1] && !pg_rd[1]));
endmodule

// File: tb/cpu_bus_router_test.sv
module cpu_bus_router_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        bus_rd, bus_wr, bus_word;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        cfg_bank_we;
  logic [3:0]  cfg_bank_sel;
  logic [5:0]  cfg_bank_base;
  logic        cfg_win_we;
  logic [1:0]  cfg_win_sel;
  logic [15:0] cfg_win_lo, cfg_win_hi;
  logic        cfg_win_en;
  logic [1:0]  dev_sel;
  logic [3:0]  dev_idx;
  logic [31:0] dev_addr;
  logic        dev_we;
  logic [15:0] dev_rdata;
  logic [1:0]  pg_rd;
  logic        pg_we;
  logic [35:0] pg_addr;
  logic [15:0] pg_rdata;
  logic [7:0]  out_wdata;

  cpu_bus_router uut (
    .clk(clk), .rst_n(rst_n),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cfg_bank_we(cfg_bank_we), .cfg_bank_sel(cfg_bank_sel), .cfg_bank_base(cfg_bank_base),
    .cfg_win_we(cfg_win_we), .cfg_win_sel(cfg_win_sel), .cfg_win_lo(cfg_win_lo),
    .cfg_win_hi(cfg_win_hi), .cfg_win_en(cfg_win_en),
    .dev_sel(dev_sel), .dev_idx(dev_idx), .dev_addr(dev_addr), .dev_we(dev_we),
    .dev_rdata(dev_rdata), .pg_rd(pg_rd), .pg_we(pg_we), .pg_addr(pg_addr),
    .pg_rdata(pg_rdata), .out_wdata(out_wdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // Behavioural reference state
  logic [7:0]  ram_m  [2048];
  logic [5:0]  base_m [16];
  logic [15:0] lo_m   [4];
  logic [15:0] hi_m   [4];
  bit          en_m   [4];
  logic [7:0]  per_m  [4][16];
  logic [7:0]  pg_m   [int];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int ref_tgt(logic [15:0] a, bit is_rd, output int idx);
    idx = 0;
    if (a < 16'h0800) return 0;
    if (is_rd && a >= 16'h8000) return 2;
    for (int i = 0; i < 4; i++) begin
      if (lo_m[i] == 16'hFFFF) return 2;
      if (en_m[i] && a >= lo_m[i] && a <= hi_m[i]) begin
        idx = i;
        return 1;
      end
    end
    return 2;
  endfunction

  function automatic int phys_of(logic [15:0] a);
    return (int'(base_m[a[15:12]]) << 12) + int'(a[11:0]);
  endfunction

  function automatic logic [7:0] pg_get(int p);
    logic [31:0] v;
    v = p;
    if (pg_m.exists(p)) return pg_m[p];
    return v[7:0] ^ v[15:8] ^ 8'h5C;
  endfunction

  function automatic logic [7:0] ref_byte(logic [15:0] a);
    int idx, t;
    t = ref_tgt(a, 1'b1, idx);
    if (t == 0) return ram_m[a[10:0]];
    if (t == 1) return per_m[idx][a[3:0]];
    return pg_get(phys_of(a));
  endfunction

  task automatic bus_cycle(bit rd, bit wr, bit word, logic [15:0] a, logic [7:0] d, string tag);
    int t0, t1, i0, i1;
    logic [15:0] a1, exp_rd;
    bit do_rd, act0, act1;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_word = word; bus_addr = a; bus_wdata = d;
    #1;
    pg_rdata  = {pg_get(int'(pg_addr[35:18])), pg_get(int'(pg_addr[17:0]))};
    dev_rdata = {per_m[dev_idx[3:2]][dev_addr[19:16]], per_m[dev_idx[1:0]][dev_addr[3:0]]};
    #1;
    do_rd = rd && !wr;
    a1 = a + 16'd1;
    t0 = ref_tgt(a, do_rd, i0);
    t1 = ref_tgt(a1, 1'b1, i1);
    act0 = rd || wr;
    act1 = do_rd && word;
    chk(tag, "dev_sel", 32'(dev_sel), 32'({act1 && t1 == 1, act0 && t0 == 1}));
    chk(tag, "pg_rd", 32'(pg_rd), 32'({act1 && t1 == 2, do_rd && t0 == 2}));
    chk(tag, "pg_we/dev_we", 32'({pg_we, dev_we}), 32'({wr && t0 == 2, wr && t0 == 1}));
    if (act0 && t0 == 1) chk(tag, "dev_idx lane0", 32'(dev_idx[1:0]), 32'(i0));
    if (act0 && t0 == 2) chk(tag, "pg_addr lane0", 32'(pg_addr[17:0]), 32'(phys_of(a)));
    if (act1 && t1 == 2) chk(tag, "pg_addr lane1", 32'(pg_addr[35:18]), 32'(phys_of(a1)));
    exp_rd = {word ? ref_byte(a1) : 8'h00, ref_byte(a)};
    @(posedge clk);
    if (wr) begin
      if (t0 == 0)      ram_m[a[10:0]] = d;
      else if (t0 == 1) per_m[i0][a[3:0]] = d;
      else              pg_m[phys_of(a)] = d;
    end
    #2;
    chk(tag, "rvalid", 32'(bus_rvalid), 32'(do_rd));
    if (do_rd) chk(tag, "rdata", 32'(bus_rdata), 32'(exp_rd));
    bus_rd = 1'b0; bus_wr = 1'b0; bus_word = 1'b0;
  endtask

  task automatic set_win(int i, logic [15:0] lo, logic [15:0] hi, bit en);
    @(negedge clk);
    cfg_win_we = 1'b1; cfg_win_sel = 2'(i); cfg_win_lo = lo; cfg_win_hi = hi; cfg_win_en = en;
    @(posedge clk);
    lo_m[i] = lo; hi_m[i] = hi; en_m[i] = en;
    #3 cfg_win_we = 1'b0;
  endtask

  task automatic set_bank(int i, logic [5:0] b);
    @(negedge clk);
    cfg_bank_we = 1'b1; cfg_bank_sel = 4'(i); cfg_bank_base = b;
    @(posedge clk);
    base_m[i] = b;
    #3 cfg_bank_we = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_rd = 0; bus_wr = 0; bus_word = 0; bus_addr = '0; bus_wdata = '0;
    cfg_bank_we = 0; cfg_bank_sel = '0; cfg_bank_base = '0;
    cfg_win_we = 0; cfg_win_sel = '0; cfg_win_lo = '0; cfg_win_hi = '0; cfg_win_en = 0;
    dev_rdata = '0; pg_rdata = '0;
    for (int i = 0; i < 16; i++) base_m[i] = 6'(i);
    for (int i = 0; i < 4; i++) begin
      lo_m[i] = 16'hFFFF; hi_m[i] = 16'hFFFF; en_m[i] = 0;
      for (int r = 0; r < 16; r++) per_m[i][r] = 8'(i * 16 + r) ^ 8'h90;
    end
    repeat (3) @(negedge clk);
    chk("R11", "rvalid in reset", 32'(bus_rvalid), 32'd0);
    chk("R11", "rdata in reset", 32'(bus_rdata), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "rvalid after reset", 32'(bus_rvalid), 32'd0);

    // R11: empty table, writes above RAM go to pages; R7 identity bases
    bus_cycle(0, 1, 0, 16'h2000, 8'hA1, "R11");
    bus_cycle(1, 0, 0, 16'h2000, 8'h00, "R11");
    bus_cycle(1, 0, 1, 16'h9234, 8'h00, "R7");

    // R1: fill the work RAM, then read it back
    for (int i = 0; i < 2048; i++) bus_cycle(0, 1, 0, 16'(i), 8'(i * 37 + 5), "R1");
    bus_cycle(1, 0, 0, 16'h0123, 8'h00, "R1");
    bus_cycle(1, 0, 0, 16'h07FF, 8'h00, "R1");
    bus_cycle(0, 0, 0, 16'h0000, 8'h00, "R9");

    // R8: word reads, including lane crossing and wrap-around
    bus_cycle(1, 0, 1, 16'h0400, 8'h00, "R8");
    bus_cycle(1, 0, 1, 16'h07FF, 8'h00, "R8");
    bus_cycle(1, 0, 1, 16'hFFFF, 8'h00, "R8");
    bus_cycle(1, 0, 0, 16'hFFFF, 8'h00, "R8");

    // Windows: overlap, high-region window, end marker later
    set_win(0, 16'h2000, 16'h2007, 1);
    set_win(1, 16'h2000, 16'h20FF, 1);
    set_win(2, 16'h9000, 16'h90FF, 1);
    bus_cycle(0, 1, 0, 16'h2003, 8'h11, "R4");
    bus_cycle(0, 1, 0, 16'h2007, 8'h22, "R4");
    bus_cycle(0, 1, 0, 16'h2008, 8'h33, "R4");
    bus_cycle(0, 1, 0, 16'h2000, 8'h44, "R4");
    bus_cycle(1, 0, 1, 16'h2007, 8'h00, "R4");
    bus_cycle(1, 0, 0, 16'h2050, 8'h00, "R4");
    bus_cycle(0, 1, 0, 16'h9010, 8'h55, "R3");
    bus_cycle(1, 0, 0, 16'h9010, 8'h00, "R2");
    bus_cycle(1, 0, 1, 16'h90FF, 8'h00, "R2");
    bus_cycle(0, 1, 0, 16'h3000, 8'h66, "R6");
    bus_cycle(1, 0, 0, 16'h3000, 8'h00, "R6");
    bus_cycle(0, 1, 0, 16'h1FFF, 8'h67, "R6");

    // R5: disabled entry skipped, end marker stops the search
    set_win(0, 16'h2000, 16'h2007, 0);
    bus_cycle(0, 1, 0, 16'h2003, 8'h77, "R5");
    set_win(1, 16'hFFFF, 16'hFFFF, 1);
    bus_cycle(0, 1, 0, 16'h9011, 8'h88, "R5");
    bus_cycle(0, 1, 0, 16'h2003, 8'h89, "R5");
    set_win(1, 16'h4000, 16'h40FF, 1);
    bus_cycle(0, 1, 0, 16'h9012, 8'h8A, "R5");

    // R7: reprogrammed bank base
    set_bank(3, 6'h2A);
    bus_cycle(0, 1, 0, 16'h3456, 8'h99, "R7");
    bus_cycle(1, 0, 1, 16'h3456, 8'h00, "R7");
    set_bank(15, 6'h3F);
    bus_cycle(1, 0, 1, 16'hEFFF, 8'h00, "R7");

    // R10: read and write together
    bus_cycle(1, 1, 1, 16'h0010, 8'hC3, "R10");
    bus_cycle(1, 0, 0, 16'h0010, 8'h00, "R10");
    bus_cycle(1, 1, 0, 16'h9020, 8'hC4, "R10");

    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      int op;
      case ($urandom_range(0, 4))
        0: a = 16'($urandom_range(0, 16'h07FF));
        1: a = 16'h2000 + 16'($urandom_range(0, 16'h10F));
        2: a = 16'h4000 + 16'($urandom_range(0, 16'h1FF));
        3: a = 16'h9000 + 16'($urandom_range(0, 16'h1FF));
        default: a = 16'($urandom);
      endcase
      op = $urandom_range(0, 9);
      if (op == 0)      set_bank($urandom_range(0, 15), 6'($urandom));
      else if (op < 4)  bus_cycle(0, 1, 0, a, 8'($urandom), "R9");
      else if (op < 7)  bus_cycle(1, 0, 1, a, 8'h00, "R8");
      else              bus_cycle(1, 0, 0, a, 8'h00, "R9");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule